// File: doc/BRIEF.md
# Routed Level-Interrupt Aggregator

This block collects nine level-sensitive interrupt sources and presents them on three interrupt request lines toward a host interrupt controller. Every source first passes through a polarity stage. Sources 1 and 8 are hardwired active-high and source 2 is hardwired active-low. The remaining sources take their sense from a configuration register. Each request line has its own register, which holds a per-source enable vector and a per-source pending vector. A source that is active and enabled on a line latches a pending bit for that line. The line is asserted while any of its enabled sources has a pending bit.

Software reaches the registers through a plain synchronous port. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. No handshake applies, because every access completes in one cycle. To acknowledge a source, software writes one to its pending bit. A pending bit written with zero keeps its value, so software can rewrite the enables without losing interrupts. The sources are levels: a source that is still active when it is acknowledged stays pending.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset, the configuration register, all enable bits and all pending bits are zero, every register reads zero, and `irq_out` is 0.
- R2: Addresses are byte offsets. The configuration register is at 0x0 and the register of line n is at 0x4+4n (0x4, 0x8, 0xC). A write to any other offset, including an unaligned one, changes nothing. A read of any other offset returns zero.
- R3: In a line register, bits [8:0] are enables and bits [24:16] are pending flags, with bit 16+n belonging to source n. All other bits read zero. The configuration register reads back its programmable bits 0 and 3..7 in [8:0]. Bits 1, 2 and 8 read zero.
- R4: A programmable source n is active while its input is 1 if configuration bit n is 1, and active while its input is 0 if configuration bit n is 0.
- R5: Source 1 and source 8 are active when their input is 1, and source 2 is active when its input is 0, whatever the configuration register holds.
- R6: When source n is active and enabled on line L at a clock edge, pending bit 16+n of line L reads one after that edge. A source that is not enabled on a line never sets that line's pending bit.
- R7: A pending bit stays set after its source goes inactive, until it is acknowledged.
- R8: Writing one to pending bit 16+n clears it if source n is inactive. If the source is still active and enabled, the bit reads one again after the write. Writing zero to a pending bit leaves it unchanged.
- R9: `irq_out[L]` is high exactly when line L has a pending bit whose enable is also set. Clearing an enable drops the output but keeps the pending bit.
- R10: Writing 0x01FF0000 to a line register clears every pending bit of that line and disables every source on it.
- R11: Each line's enables are independent. A source enabled only on line L never raises another line's output or pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 9 | Raw interrupt source levels, one per source |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_addr | input | 5 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 3 | Interrupt request lines, active high |

## Verification
The in-RTL properties check, on every cycle, that pending flags set, hold and clear according to the active/enable state and acknowledge writes. They also check that enables load on writes, that a line with no enables stays quiet, and that reserved bits and unmapped offsets always read zero. Only the bench scenarios can show that the register map routes each source to the intended line. The same holds for the polarity of the fixed and programmable sources under both configuration values, and for the acknowledge-while-active, mask-but-keep-pending and clear-all write sequences. These effects involve the decode and polarity stages together over several accesses.

// File: rtl/lir_pkg.sv
package lir_pkg;
  // polarity class of one source
  typedef enum logic [1:0] {
    SENSE_PROG = 2'd0,
    SENSE_HIGH = 2'd1,
    SENSE_LOW  = 2'd2
  } sense_e;

  function automatic sense_e sense_of(input logic hi, input logic lo);
    if (hi) return SENSE_HIGH;
    if (lo) return SENSE_LOW;
    return SENSE_PROG;
  endfunction
endpackage

// File: rtl/lir_cfg_reg.sv
module lir_cfg_reg #(
  parameter int unsigned NSRC = 9,
  parameter logic [NSRC-1:0] PROG_MASK = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] cfg_o
);
  logic [NSRC-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cfg_q <= '0;
    else if (wr_i) cfg_q <= wdata_i & PROG_MASK;
  end

  assign cfg_o = cfg_q;

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> cfg_o == ($past(wdata_i) & PROG_MASK)); // R3
endmodule

// File: rtl/lir_polarity.sv
module lir_polarity
  import lir_pkg::*;
#(
  parameter int unsigned NSRC = 9,
  parameter logic [NSRC-1:0] FIX_HIGH = '0,
  parameter logic [NSRC-1:0] FIX_LOW  = '0
) (
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] cfg_i,
  output logic [NSRC-1:0] act_o
);
  localparam logic [NSRC-1:0] FIXED = FIX_HIGH | FIX_LOW;

  // configuration bits of hardwired sources are not consulted
  logic unused_cfg;
  assign unused_cfg = ^(cfg_i & FIXED);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    localparam sense_e KIND = sense_of(FIX_HIGH[k], FIX_LOW[k]);
    if (KIND == SENSE_HIGH) begin : g_hi
      assign act_o[k] = src_i[k];
    end else if (KIND == SENSE_LOW) begin : g_lo
      assign act_o[k] = ~src_i[k];
    end else begin : g_prog
      assign act_o[k] = ~(src_i[k] ^ cfg_i[k]);
    end
  end
endmodule

// File: rtl/lir_line.sv
module lir_line #(
  parameter int unsigned NSRC = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] act_i,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wen_i,
  input  logic [NSRC-1:0] wclr_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] pend_o,
  output logic            irq_o
);
  logic [NSRC-1:0] en_q, pend_q, clr_mask, pend_d;

  assign clr_mask = wr_i ? wclr_i : '0;
  // a still-active enabled source re-pends in the same edge it is acknowledged
  assign pend_d   = (pend_q & ~clr_mask) | (act_i & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_i) en_q <= wen_i;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_q);

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> en_q == $past(wen_i)); // R11
  AST_NO_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o); // R9

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i[k] && en_q[k]) |=> pend_q[k]); // R6
    AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[k] && !(act_i[k] && en_q[k])) |=> !pend_q[k]); // R6
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[k] && !(wr_i && wclr_i[k])) |=> pend_q[k]); // R7
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wclr_i[k] && !(act_i[k] && en_q[k])) |=> !pend_q[k]); // R8
  end
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router #(
  parameter int unsigned NSRC     = 9,
  parameter int unsigned NLINE    = 3,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned STAT_LSB = 16,
  parameter logic [NSRC-1:0] FIX_HIGH = 9'h102,
  parameter logic [NSRC-1:0] FIX_LOW  = 9'h004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NLINE-1:0]  irq_out
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam logic [NSRC-1:0]   PROG_MASK = ~(FIX_HIGH | FIX_LOW);
  localparam logic [DATA_W-1:0] EN_FIELD  = DATA_W'({NSRC{1'b1}});
  localparam logic [DATA_W-1:0] LEGAL     = EN_FIELD | (EN_FIELD << STAT_LSB);

  logic              aligned;
  logic [WIDX_W-1:0] word_idx;
  logic              cfg_hit;
  logic [NLINE-1:0]  line_hit;
  logic [NSRC-1:0]   cfg, act;
  logic [NSRC-1:0]   en_a   [NLINE];
  logic [NSRC-1:0]   pend_a [NLINE];
  logic              unused_wbits;

  assign unused_wbits = ^(reg_wdata & ~LEGAL);
  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign word_idx = reg_addr[ADDR_W-1:2];
  assign cfg_hit  = aligned && (word_idx == '0);

  lir_cfg_reg #(.NSRC(NSRC), .PROG_MASK(PROG_MASK)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr && cfg_hit),
    .wdata_i (reg_wdata[NSRC-1:0]),
    .cfg_o   (cfg)
  );

  lir_polarity #(.NSRC(NSRC), .FIX_HIGH(FIX_HIGH), .FIX_LOW(FIX_LOW)) u_pol (
    .src_i (src_in),
    .cfg_i (cfg),
    .act_o (act)
  );

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    assign line_hit[g] = aligned && (word_idx == WIDX_W'(g + 1));
    lir_line #(.NSRC(NSRC)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (act),
      .wr_i   (reg_wr && line_hit[g]),
      .wen_i  (reg_wdata[NSRC-1:0]),
      .wclr_i (reg_wdata[STAT_LSB +: NSRC]),
      .en_o   (en_a[g]),
      .pend_o (pend_a[g]),
      .irq_o  (irq_out[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (cfg_hit) reg_rdata[NSRC-1:0] = cfg;
    for (int i = 0; i < NLINE; i++) begin
      if (line_hit[i]) begin
        reg_rdata[NSRC-1:0]         = en_a[i];
        reg_rdata[STAT_LSB +: NSRC] = pend_a[i];
      end
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~LEGAL) == '0); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_hit || (|line_hit)) |-> (reg_rdata == '0)); // R2
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_hit, line_hit})); // R2
endmodule

// File: tb/lvl_irq_router_test.sv
module lvl_irq_router_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  src_in = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  lvl_irq_router uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // R4 / R5: sense of each source as required
  function automatic bit act_high(input int n, input bit p);
    if (n == 1 || n == 8) return 1'b1;
    if (n == 2) return 1'b0;
    return p;
  endfunction

  function automatic logic [8:0] idle_vec(input bit p);
    logic [8:0] v;
    for (int n = 0; n < 9; n++) v[n] = act_high(n, p) ? 1'b0 : 1'b1;
    return v;
  endfunction

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state; src_in all zero makes active-low sources active but nothing is enabled
    tick();
    chk(irq_out == 3'b0, "R1 irq after reset", irq_out, 0);
    for (int a = 0; a < 16; a += 4) begin
      rd(5'(a), d);
      chk(d == 32'h0, "R1 register after reset", d, 0);
    end

    // R2: unmapped and unaligned writes ignored, reads zero
    wr(5'h10, 32'h01FF01FF);
    wr(5'h05, 32'h000001FF);
    wr(5'h01, 32'h000001FF);
    rd(5'h10, d); chk(d == 0, "R2 unmapped read", d, 0);
    rd(5'h05, d); chk(d == 0, "R2 unaligned read", d, 0);
    rd(5'h04, d); chk(d == 0, "R2 line0 untouched", d, 0);
    rd(5'h00, d); chk(d == 0, "R2 cfg untouched", d, 0);
    tick();
    chk(irq_out == 0, "R2 no irq from ignored write", irq_out, 0);

    for (int p = 0; p < 2; p++) begin
      // R3: cfg readback of programmable bits only
      wr(5'h00, p ? 32'hFFFF_FFFF : 32'h0);
      rd(5'h00, d);
      chk(d == (p ? 32'h0F9 : 32'h0), "R3 cfg readback", d, p ? 32'h0F9 : 0);
      for (int l = 0; l < 3; l++) begin
        for (int s = 0; s < 9; s++) begin
          logic [4:0] la;
          logic [31:0] en_v, pd_v;
          la = 5'(4 + 4 * l);
          en_v = 32'(1) << s;
          pd_v = 32'(1) << (16 + s);
          src_in = idle_vec(p[0]);
          wr(la, en_v);
          rd(la, d);
          chk(d == en_v, "R4/R5 inactive level gives no pending (R6)", d, en_v);
          chk(irq_out == 0, "R6 no irq while inactive", irq_out, 0);
          // activate the source
          src_in[s] = act_high(s, p[0]);
          tick();
          chk(irq_out == 3'(1 << l), "R9 R11 irq routed to line", irq_out, 1 << l);
          rd(la, d);
          chk(d == (en_v | pd_v), "R6 pending set", d, en_v | pd_v);
          for (int o = 0; o < 3; o++) if (o != l) begin
            rd(5'(4 + 4 * o), d);
            chk(d == 0, "R11 other line untouched", d, 0);
          end
          // go inactive: pending holds
          src_in[s] = ~act_high(s, p[0]);
          tick();
          rd(la, d);
          chk(d == (en_v | pd_v), "R7 pending held", d, en_v | pd_v);
          // write 0 to pending bits keeps them (R8)
          wr(la, en_v);
          rd(la, d);
          chk(d == (en_v | pd_v), "R8 write zero keeps pending", d, en_v | pd_v);
          // acknowledge while inactive
          wr(la, en_v | pd_v);
          rd(la, d);
          chk(d == en_v, "R8 ack clears", d, en_v);
          chk(irq_out == 0, "R9 irq drops after ack", irq_out, 0);
          // acknowledge while still active: re-pends
          src_in[s] = act_high(s, p[0]);
          tick();
          wr(la, en_v | pd_v);
          rd(la, d);
          chk(d == (en_v | pd_v), "R8 re-pend while active", d, en_v | pd_v);
          // disable without clearing
          wr(la, 32'h0);
          #1;
          chk(irq_out == 0, "R9 masked drops irq", irq_out, 0);
          rd(la, d);
          chk(d == pd_v, "R9 masked keeps pending", d, pd_v);
          // clear-all write
          wr(la, 32'h01FF0000);
          rd(la, d);
          chk(d == 0, "R10 clear all", d, 0);
        end
      end
    end

    // R10 with several pending at once
    wr(5'h00, 32'h0);
    src_in = 9'h000;
    wr(5'h08, 32'h000001FF);
    tick();
    rd(5'h08, d);
    chk(d == 32'h00FD01FF, "R5 R6 multi pending", d, 32'h00FD01FF);
    src_in = idle_vec(1'b0);
    wr(5'h08, 32'h01FF0000);
    rd(5'h08, d);
    chk(d == 0, "R10 clear multi", d, 0);
    chk(irq_out == 0, "R10 irq low", irq_out, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule